// File: doc/BRIEF.md
# Width- and Byte-Order-Selectable Buffer Data Port

This block is the processor-side data window into a byte-addressed packet buffer. The buffer is shared with a serial interface engine. A host agent, either the CPU or a DMA engine, moves data through one 32-bit bus word per access. The bus word is read as 8, 16 or 32 bits wide and as little- or big-endian. The block steers the active bus byte lanes onto consecutive buffer bytes that start at an internal byte pointer. The pointer then advances past the bytes that were moved. Reads take the same path in reverse: buffer bytes are placed back onto their lanes, and unused lanes return zero.

Every access is checked against two conditions: the port ready flag, and the owner of the buffer (the host side or the serial engine). An access that fails either check is refused. A refused access raises an error pulse, changes no buffer byte and does not move the pointer. A small configuration store holds the access width, the byte order and the pipe selected on the port. A configuration write is refused as a whole in three cases: it would change the pipe while port functions are locked, it names a pipe already bound to another port, or it carries an illegal code. The serial engine side reads buffer bytes through a byte-wide read port.

Top module: `efp_fifo_port`

## Requirements
- R1: With width code 2'b10 (32-bit), little-endian places bus bits [8k+7:8k] at buffer byte pointer+k. Big-endian places bus bits [31:24] at pointer+0, [23:16] at pointer+1, [15:8] at pointer+2 and [7:0] at pointer+3. Reads return the same mapping.
- R2: With width code 2'b01 (16-bit), only bus bits [15:0] are used. Little-endian: [7:0] maps to pointer+0 and [15:8] to pointer+1. Big-endian: [15:8] maps to pointer+0 and [7:0] to pointer+1. Written bits [31:16] change no buffer byte, and read bits [31:16] return zero.
- R3: With width code 2'b00 (8-bit), the single active lane is bus bits [7:0] for little-endian and bits [15:8] for big-endian. That lane maps to pointer+0. The other lanes write nothing and read as zero.
- R4: Each accepted access advances the byte pointer by 4, 2 or 1 for the 32-, 16- or 8-bit width. The pointer wraps modulo the buffer depth, and the bytes of one access wrap the same way.
- R5: An access made while port_rdy is 0 or sie_owns is 1 pulses acc_err in the next cycle. Such an access leaves every buffer byte and the pointer unchanged, and it returns acc_rdata of zero. An accepted access leaves acc_err at 0.
- R6: While func_lock is 1, a configuration write whose pipe differs from cur_pipe is refused. The refusal pulses cfg_err and keeps every configuration field. A write with the same pipe is still accepted.
- R7: A configuration write is refused, with cfg_err and no field change, if it names a pipe whose bit is set in other_busy, a pipe number of NPIPE or more, or the reserved width code 2'b11.
- R8: After reset the pointer is 0, the width is 8-bit (2'b00), the byte order is little-endian, the pipe is 0, acc_rdata is 0 and both error outputs are 0.
- R9: A ptr_clr pulse sets the byte pointer to 0 in the next cycle.
- R10: acc_rdata and acc_err are registered. They show the result of an access in the cycle after it is presented. In any cycle without an accepted read, acc_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_width | input | 2 | Width code: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| cfg_big | input | 1 | Byte order: 1 = big-endian |
| cfg_pipe | input | PW | Pipe number to select |
| func_lock | input | 1 | Port functions in use; the pipe must not change |
| other_busy | input | NPIPE | Pipes currently bound to other ports |
| cfg_err | output | 1 | Configuration write was refused (one-cycle pulse) |
| cur_width | output | 2 | Active width code |
| cur_big | output | 1 | Active byte order |
| cur_pipe | output | PW | Selected pipe |
| port_rdy | input | 1 | Port ready flag |
| sie_owns | input | 1 | Buffer is owned by the serial engine side |
| ptr_clr | input | 1 | Clear the byte pointer |
| acc_valid | input | 1 | Data access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Bus write word |
| acc_rdata | output | 32 | Bus read word (registered) |
| acc_err | output | 1 | Access was refused (one-cycle pulse) |
| byte_ptr | output | AW | Current buffer byte pointer |
| sie_addr | input | AW | Serial engine side byte read address |
| sie_rdata | output | 8 | Buffer byte at sie_addr |

## Verification
A lane steering fault shows up at once as a byte at the wrong address. The sie_rdata port exposes that misplaced byte in the same cycle the write lands. The same fault also shows as a swapped or non-zero lane in acc_rdata one cycle after a read. A wrong pointer step shows on byte_ptr in the cycle after the access. If the fault is in the address window instead, every later byte of the packet lands at a shifted address. A gating or configuration fault shows as a missing error pulse, or as a changed field on cur_pipe or cur_width, in the cycle after the refused request.

// File: rtl/efp_pkg.sv
package efp_pkg;

  typedef enum logic [1:0] {
    W8   = 2'b00,
    W16  = 2'b01,
    W32  = 2'b10,
    WRSV = 2'b11
  } acc_width_e;

  // number of buffer bytes moved by one access of the given width
  function automatic logic [2:0] width_bytes(input acc_width_e w);
    case (w)
      W32:     return 3'd4;
      W16:     return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // whether a bus lane carries data for this width and byte order
  function automatic logic lane_used(input acc_width_e w, input logic big,
                                     input logic [1:0] lane);
    case (w)
      W32:     return 1'b1;
      W16:     return ~lane[1];
      default: return lane == (big ? 2'd1 : 2'd0);
    endcase
  endfunction

  // byte offset from the pointer that a used lane maps onto
  function automatic logic [1:0] lane_offset(input acc_width_e w, input logic big,
                                             input logic [1:0] lane);
    case (w)
      W32:     return big ? (2'd3 - lane) : lane;
      W16:     return big ? {1'b0, ~lane[0]} : {1'b0, lane[0]};
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/efp_lane_steer.sv
module efp_lane_steer
  import efp_pkg::*;
(
  input  acc_width_e       width,
  input  logic             big,
  input  logic [31:0]      bus_wdata,
  input  logic [3:0][7:0]  win_bytes,
  output logic [3:0][7:0]  wr_bytes,
  output logic [3:0]       wr_mask,
  output logic [31:0]      bus_rdata
);

  logic [3:0]      lane_on;
  logic [3:0][1:0] lane_off;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_on[l]  = lane_used(width, big, 2'(l));
    assign lane_off[l] = lane_offset(width, big, 2'(l));
    assign bus_rdata[8*l +: 8] = lane_on[l] ? win_bytes[lane_off[l]] : 8'h00;
  end

  // scatter bus lanes onto buffer byte offsets
  always_comb begin
    wr_bytes = '0;
    wr_mask  = '0;
    for (int l = 0; l < 4; l++) begin
      if (lane_on[l]) begin
        wr_mask[lane_off[l]]  = 1'b1;
        wr_bytes[lane_off[l]] = bus_wdata[8*l +: 8];
      end
    end
  end

endmodule

// File: rtl/efp_byte_buf.sv
module efp_byte_buf #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   base,
  input  logic            wr_en,
  input  logic [3:0]      wr_mask,
  input  logic [3:0][7:0] wr_bytes,
  output logic [3:0][7:0] win_bytes,
  input  logic [AW-1:0]   sie_addr,
  output logic [7:0]      sie_rdata
);

  logic [7:0]           mem [DEPTH];
  logic [3:0][AW-1:0]   win_addr;

  // four-byte window starting at the pointer, wrapping at the depth
  for (genvar i = 0; i < 4; i++) begin : g_win
    assign win_addr[i]  = base + AW'(i);
    assign win_bytes[i] = mem[win_addr[i]];
  end

  assign sie_rdata = mem[sie_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < 4; i++) begin
        if (wr_mask[i]) mem[win_addr[i]] <= wr_bytes[i];
      end
    end
  end

endmodule

// File: rtl/efp_cfg.sv
module efp_cfg
  import efp_pkg::*;
#(
  parameter  int NPIPE = 10,
  localparam int PW    = $clog2(NPIPE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_big,
  input  logic [PW-1:0]    cfg_pipe,
  input  logic             func_lock,
  input  logic [NPIPE-1:0] other_busy,
  output acc_width_e       width_q,
  output logic             big_q,
  output logic [PW-1:0]    pipe_q,
  output logic             cfg_err_q,
  output logic             cfg_reject
);

  logic pipe_range_bad;
  logic pipe_taken;
  logic pipe_moves;
  logic width_bad;

  assign pipe_range_bad = 32'(cfg_pipe) >= NPIPE;
  assign pipe_taken     = !pipe_range_bad && other_busy[cfg_pipe];
  assign pipe_moves     = cfg_pipe != pipe_q;
  assign width_bad      = cfg_width == WRSV;
  assign cfg_reject     = cfg_we && (width_bad || pipe_range_bad || pipe_taken ||
                                     (func_lock && pipe_moves));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q   <= W8;
      big_q     <= 1'b0;
      pipe_q    <= '0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_reject;
      if (cfg_we && !cfg_reject) begin
        width_q <= acc_width_e'(cfg_width);
        big_q   <= cfg_big;
        pipe_q  <= cfg_pipe;
      end
    end
  end

endmodule

// File: rtl/efp_fifo_port.sv
module efp_fifo_port
  import efp_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int NPIPE = 10,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(NPIPE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_big,
  input  logic [PW-1:0]    cfg_pipe,
  input  logic             func_lock,
  input  logic [NPIPE-1:0] other_busy,
  output logic             cfg_err,
  output logic [1:0]       cur_width,
  output logic             cur_big,
  output logic [PW-1:0]    cur_pipe,
  input  logic             port_rdy,
  input  logic             sie_owns,
  input  logic             ptr_clr,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             acc_err,
  output logic [AW-1:0]    byte_ptr,
  input  logic [AW-1:0]    sie_addr,
  output logic [7:0]       sie_rdata
);

  acc_width_e      width_q;
  logic            big_q;
  logic            cfg_reject;
  logic [3:0][7:0] win_bytes;
  logic [3:0][7:0] wr_bytes;
  logic [3:0]      wr_mask;
  logic [31:0]     steer_rdata;
  logic [AW-1:0]   ptr_q;
  logic [31:0]     rdata_q;
  logic            err_q;

  // named access events
  logic acc_allowed;
  logic acc_fire;
  logic acc_block;
  logic wr_fire;
  logic rd_fire;

  assign acc_allowed = port_rdy && !sie_owns;
  assign acc_fire    = acc_valid && acc_allowed;
  assign acc_block   = acc_valid && !acc_allowed;
  assign wr_fire     = acc_fire && acc_write;
  assign rd_fire     = acc_fire && !acc_write;

  efp_cfg #(.NPIPE(NPIPE)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_width  (cfg_width),
    .cfg_big    (cfg_big),
    .cfg_pipe   (cfg_pipe),
    .func_lock  (func_lock),
    .other_busy (other_busy),
    .width_q    (width_q),
    .big_q      (big_q),
    .pipe_q     (cur_pipe),
    .cfg_err_q  (cfg_err),
    .cfg_reject (cfg_reject)
  );

  efp_lane_steer u_steer (
    .width     (width_q),
    .big       (big_q),
    .bus_wdata (acc_wdata),
    .win_bytes (win_bytes),
    .wr_bytes  (wr_bytes),
    .wr_mask   (wr_mask),
    .bus_rdata (steer_rdata)
  );

  efp_byte_buf #(.DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (ptr_q),
    .wr_en     (wr_fire),
    .wr_mask   (wr_mask),
    .wr_bytes  (wr_bytes),
    .win_bytes (win_bytes),
    .sie_addr  (sie_addr),
    .sie_rdata (sie_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_fire ? steer_rdata : 32'h0;
      err_q   <= acc_block;
      if (ptr_clr)       ptr_q <= '0;
      else if (acc_fire) ptr_q <= ptr_q + AW'(width_bytes(width_q));
    end
  end

  assign cur_width = width_q;
  assign cur_big   = big_q;
  assign byte_ptr  = ptr_q;
  assign acc_rdata = rdata_q;
  assign acc_err   = err_q;

endmodule

// File: rtl/efp_fifo_port_chk.sv
module efp_fifo_port_chk #(
  parameter  int DEPTH = 64,
  parameter  int NPIPE = 10,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(NPIPE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             port_rdy,
  input logic             sie_owns,
  input logic             ptr_clr,
  input logic [1:0]       cur_width,
  input logic             cur_big,
  input logic [PW-1:0]    cur_pipe,
  input logic [31:0]      acc_rdata,
  input logic             acc_err,
  input logic [AW-1:0]    byte_ptr,
  input logic             cfg_we,
  input logic [PW-1:0]    cfg_pipe,
  input logic             func_lock,
  input logic [NPIPE-1:0] other_busy,
  input logic             cfg_err,
  input logic             acc_fire
);

  logic [AW-1:0] step_now;
  logic [AW-1:0] ptr_after;
  logic          pipe_busy_req;

  assign step_now      = (cur_width == 2'b10) ? AW'(4) :
                         (cur_width == 2'b01) ? AW'(2) : AW'(1);
  assign ptr_after     = byte_ptr + step_now;
  assign pipe_busy_req = (32'(cfg_pipe) < NPIPE) && other_busy[cfg_pipe];

  // R5
  blocked_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (!port_rdy || sie_owns) && !ptr_clr
    |=> acc_err && acc_rdata == 32'h0 && byte_ptr == $past(byte_ptr));

  // R5
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_err);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !ptr_clr |=> byte_ptr == $past(ptr_after));

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> byte_ptr == '0);

  // R2
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_write && cur_width == 2'b01 |=> acc_rdata[31:16] == 16'h0);

  // R3
  byte_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_write && cur_width == 2'b00
    |=> acc_rdata[31:16] == 16'h0 &&
        ($past(cur_big) ? acc_rdata[7:0] == 8'h0 : acc_rdata[15:8] == 8'h0));

  // R6
  pipe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && func_lock && cfg_pipe != cur_pipe
    |=> cfg_err && cur_pipe == $past(cur_pipe));

  // R7
  busy_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && pipe_busy_req |=> cfg_err && cur_pipe == $past(cur_pipe));

endmodule

bind efp_fifo_port efp_fifo_port_chk #(.DEPTH(DEPTH), .NPIPE(NPIPE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .port_rdy   (port_rdy),
  .sie_owns   (sie_owns),
  .ptr_clr    (ptr_clr),
  .cur_width  (cur_width),
  .cur_big    (cur_big),
  .cur_pipe   (cur_pipe),
  .acc_rdata  (acc_rdata),
  .acc_err    (acc_err),
  .byte_ptr   (byte_ptr),
  .cfg_we     (cfg_we),
  .cfg_pipe   (cfg_pipe),
  .func_lock  (func_lock),
  .other_busy (other_busy),
  .cfg_err    (cfg_err),
  .acc_fire   (acc_fire)
);

// File: tb/efp_fifo_port_test.sv
`timescale 1ns/1ps
module efp_fifo_port_test;

  localparam int DEPTH = 64;
  localparam int NPIPE = 10;
  localparam int AW    = 6;
  localparam int PW    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_width;
  logic             cfg_big;
  logic [PW-1:0]    cfg_pipe;
  logic             func_lock;
  logic [NPIPE-1:0] other_busy;
  logic             cfg_err;
  logic [1:0]       cur_width;
  logic             cur_big;
  logic [PW-1:0]    cur_pipe;
  logic             port_rdy;
  logic             sie_owns;
  logic             ptr_clr;
  logic             acc_valid;
  logic             acc_write;
  logic [31:0]      acc_wdata;
  logic [31:0]      acc_rdata;
  logic             acc_err;
  logic [AW-1:0]    byte_ptr;
  logic [AW-1:0]    sie_addr;
  logic [7:0]       sie_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  efp_fifo_port #(.DEPTH(DEPTH), .NPIPE(NPIPE)) uut (.*);

  // {width[98:97], big[96], wdata[95:64], buffer bytes b3..b0 [63:32], readback [31:0]}
  localparam logic [98:0] VEC [6] = '{
    {2'b10, 1'b0, 32'hA3B2C1D0, 32'hA3B2C1D0, 32'hA3B2C1D0},
    {2'b10, 1'b1, 32'hA3B2C1D0, 32'hD0C1B2A3, 32'hA3B2C1D0},
    {2'b01, 1'b0, 32'h55667788, 32'h00007788, 32'h00007788},
    {2'b01, 1'b1, 32'h55667788, 32'h00008877, 32'h00007788},
    {2'b00, 1'b0, 32'h11223344, 32'h00000044, 32'h00000044},
    {2'b00, 1'b1, 32'h11223344, 32'h00000033, 32'h00003300}
  };

  logic [31:0] last_rd;
  logic        last_err;
  logic        last_cfg_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] w, input logic b, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_width = w; cfg_big = b; cfg_pipe = PW'(p);
    @(negedge clk);
    last_cfg_err = cfg_err;
    cfg_we = 1'b0;
  endtask

  task automatic do_acc(input logic wr, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wdata = d;
    @(negedge clk);
    last_rd  = acc_rdata;
    last_err = acc_err;
    acc_valid = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    ptr_clr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] b);
    sie_addr = AW'(a);
    #0.5;
    b = sie_rdata;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] keep;
    rst_n = 1'b0;
    cfg_we = 0; cfg_width = 0; cfg_big = 0; cfg_pipe = 0;
    func_lock = 0; other_busy = '0; port_rdy = 1; sie_owns = 0;
    ptr_clr = 0; acc_valid = 0; acc_write = 0; acc_wdata = 0; sie_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk("R8 ptr", 32'(byte_ptr), 0);
    chk("R8 width", 32'(cur_width), 0);
    chk("R8 big", 32'(cur_big), 0);
    chk("R8 pipe", 32'(cur_pipe), 0);
    chk("R8 rdata", acc_rdata, 0);
    chk("R8 errs", {30'h0, acc_err, cfg_err}, 0);

    // table: write then read back in every width/order combination
    for (int i = 0; i < 6; i++) begin
      logic [98:0] v;
      int k;
      string req;
      v = VEC[i];
      k = (v[98:97] == 2'b10) ? 4 : (v[98:97] == 2'b01) ? 2 : 1;
      req = (k == 4) ? "R1" : (k == 2) ? "R2" : "R3";
      do_cfg(v[98:97], v[96], 3);
      do_clr();
      do_acc(1'b1, v[95:64]);
      chk("R4 step", 32'(byte_ptr), k);
      chk("R10 write no err", 32'(last_err), 0);
      for (int j = 0; j < k; j++) begin
        peek(j, b);
        chk(req, 32'(b), 32'(v[32 + 8*j +: 8]));
      end
      do_clr();
      do_acc(1'b0, 32'h0);
      chk(req, last_rd, v[31:0]);
    end

    // R4 mixed widths, unaligned 32-bit access
    do_cfg(2'b00, 1'b0, 3);
    do_clr();
    for (int i = 0; i < 3; i++) do_acc(1'b1, 32'(8'h60 + i));
    chk("R4 three bytes", 32'(byte_ptr), 3);
    do_cfg(2'b01, 1'b0, 3);
    do_acc(1'b1, 32'h00001234);
    chk("R4 half", 32'(byte_ptr), 5);
    do_cfg(2'b10, 1'b0, 3);
    do_acc(1'b1, 32'hCAFEF00D);
    chk("R4 word", 32'(byte_ptr), 9);
    peek(8, b);
    chk("R1 unaligned top byte", 32'(b), 32'hCA);
    peek(5, b);
    chk("R1 unaligned low byte", 32'(b), 32'h0D);

    // R9 clear
    do_clr();
    chk("R9 clear", 32'(byte_ptr), 0);

    // R4 wrap: 16 words fill 64 bytes
    for (int i = 0; i < 16; i++) do_acc(1'b1, 32'(i));
    chk("R4 wrap", 32'(byte_ptr), 0);
    do_clr();
    do_cfg(2'b10, 1'b0, 3);
    // pointer at 62: a word spans 62,63,0,1
    for (int i = 0; i < 31; i++) begin
      do_cfg(2'b01, 1'b0, 3);
      do_acc(1'b1, 32'h0);
    end
    do_cfg(2'b10, 1'b0, 3);
    do_acc(1'b1, 32'h44332211);
    peek(0, b);
    chk("R4 wrapped byte", 32'(b), 32'h33);
    chk("R4 wrapped ptr", 32'(byte_ptr), 2);

    // R2 upper half of a 16-bit write is ignored
    do_cfg(2'b01, 1'b0, 3);
    do_clr();
    peek(2, keep);
    do_acc(1'b1, 32'hAABBCCDD);
    peek(2, b);
    chk("R2 upper ignored", 32'(b), 32'(keep));
    peek(1, b);
    chk("R2 odd byte", 32'(b), 32'hCC);

    // R5 gating
    do_cfg(2'b10, 1'b0, 3);
    do_clr();
    do_acc(1'b1, 32'h11111111);
    do_clr();
    port_rdy = 1'b0;
    do_acc(1'b1, 32'h22222222);
    chk("R5 err not ready", 32'(last_err), 1);
    chk("R5 ptr held", 32'(byte_ptr), 0);
    peek(0, b);
    chk("R5 buffer held", 32'(b), 32'h11);
    port_rdy = 1'b1;
    sie_owns = 1'b1;
    do_acc(1'b0, 32'h0);
    chk("R5 err owned", 32'(last_err), 1);
    chk("R5 rdata zero", last_rd, 0);
    sie_owns = 1'b0;
    do_acc(1'b0, 32'h0);
    chk("R5 accepted read", last_rd, 32'h11111111);
    chk("R5 no err", 32'(last_err), 0);
    @(negedge clk);
    chk("R10 idle rdata", acc_rdata, 0);

    // R6 pipe lock
    func_lock = 1'b1;
    do_cfg(2'b10, 1'b0, 5);
    chk("R6 refused", 32'(last_cfg_err), 1);
    chk("R6 pipe kept", 32'(cur_pipe), 3);
    do_cfg(2'b01, 1'b0, 3);
    chk("R6 same pipe ok", 32'(last_cfg_err), 0);
    chk("R6 width applied", 32'(cur_width), 1);
    func_lock = 1'b0;

    // R7 busy pipe, range, reserved width
    other_busy = 10'b00_0100_0000;
    do_cfg(2'b10, 1'b1, 6);
    chk("R7 busy", 32'(last_cfg_err), 1);
    chk("R7 pipe kept", 32'(cur_pipe), 3);
    chk("R7 big kept", 32'(cur_big), 0);
    do_cfg(2'b10, 1'b0, 12);
    chk("R7 range", 32'(last_cfg_err), 1);
    do_cfg(2'b11, 1'b0, 7);
    chk("R7 reserved", 32'(last_cfg_err), 1);
    chk("R7 width kept", 32'(cur_width), 1);
    do_cfg(2'b10, 1'b1, 7);
    chk("R7 accepted", 32'(cur_pipe), 7);
    chk("R7 no err", 32'(last_cfg_err), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule